// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This unit reports how many zero bits stand in a row at one end of a 64-bit operand. A direction select picks the end: the most significant end for leading zeros, bit 0 for trailing zeros. A word-mode select limits the scan to the low 32-bit word and ignores the upper word.

The count comes out as an unsigned number in the low bits of a 64-bit result, with every bit above it zero. When no set bit is found, the count saturates at the width being examined: 64 for a full operand and 32 for a word. The unit is purely combinational. It has no clock or state, and its result settles within one cycle of the enclosing pipeline.

A single leading-zero tree serves all four mode combinations. The operand is first mirrored when the trailing direction is selected. In word mode the active half is moved into place above a forced one, which caps the count at 32.

Top module: `zero_count_unit`

## Requirements
- R1: The result is zero in bits 63..7. The count sits in bits 6..0 as an unsigned value.
- R2: With word mode off and direction 0, the result equals 63 minus the index of the highest set bit. Bits below that set bit have no effect.
- R3: With word mode off and direction 1, the result equals the index of the lowest set bit. Bits above that set bit have no effect.
- R4: With word mode off, an operand of all zeros gives 64 in both directions.
- R5: With word mode on, the value of bits 63..32 has no effect on the result in either direction.
- R6: With word mode on and direction 0, the result equals 31 minus the index of the highest set bit within bits 31..0.
- R7: With word mode on and direction 1, the result equals the index of the lowest set bit if that index is below 32. Otherwise it is 32.
- R8: With word mode on, a low word of all zeros gives 32 in both directions, whatever bits 63..32 hold.
- R9: The result follows any change of the operand or of either select within the same clock period, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Value whose zero run is counted |
| from_lsb_i | input | 1 | 0 selects leading zeros (from the top), 1 selects trailing zeros (from bit 0) |
| word_mode_i | input | 1 | 1 restricts the scan to bits 31..0 |
| count_o | output | 64 | Zero-extended count of consecutive zeros |

## Verification
Two functions can act on the same input at once: ignoring the upper word and capping the count at 32. This happens in the trailing direction in word mode, when the only set bits lie at or above bit 32. The upper word must then neither shorten the count nor push it past 32. The bench provokes this by walking a single set bit through all 64 positions with random ones placed on its far side. It also repeats random operands with the upper word inverted. Each result is judged against a loop-based reference count and against the result for the unmodified operand.

// File: rtl/zc_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing for the zero counter.
// Assumes the operand width and the group width are powers of two.
package zc_pkg;
    localparam int unsigned OPERAND_W = 64;
    localparam int unsigned GROUP_W   = 8;

    // Width needed to hold a count from 0 to w inclusive.
    function automatic int unsigned cnt_width(input int unsigned w);
        return $clog2(w) + 1;
    endfunction
endpackage

// File: rtl/zc_operand_prep.sv
`timescale 1ns/1ps
// Module: zc_operand_prep
// Turns the operand into a vector whose leading-zero count is the answer
// for the selected mode. The trailing direction mirrors the operand.
// Word mode places the active 32-bit half on top, followed by a forced one
// that caps the count at half the width.
// Assumes WIDTH is even.
module zc_operand_prep #(
    parameter int unsigned WIDTH = zc_pkg::OPERAND_W
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic             from_lsb_i,
    input  logic             word_mode_i,
    output logic [WIDTH-1:0] scan_o
);
    localparam int unsigned HALF = WIDTH / 2;

    logic [WIDTH-1:0] mirrored;
    logic [WIDTH-1:0] oriented;
    logic [HALF-1:0]  half_src;

    // Bit mirror of the whole operand: bit 0 moves to the top.
    for (genvar b = 0; b < WIDTH; b++) begin : g_mirror
        assign mirrored[b] = operand_i[WIDTH-1-b];
    end

    // Pick the orientation and the active half for the selected direction.
    always_comb begin
        oriented = from_lsb_i ? mirrored : operand_i;
        half_src = from_lsb_i ? mirrored[WIDTH-1:HALF] : operand_i[HALF-1:0];
    end

    // Word mode: active half on top, then a stop bit, then zeros.
    always_comb begin
        if (word_mode_i) begin
            scan_o = {half_src, 1'b1, {(HALF-1){1'b0}}};
        end else begin
            scan_o = oriented;
        end
    end
endmodule

// File: rtl/zc_group_lzc.sv
`timescale 1ns/1ps
// Module: zc_group_lzc
// Leading-zero count for one small group of W bits, plus a flag that is
// set when the whole group is zero. Intended for groups of 8 bits or fewer,
// so the priority scan stays shallow.
// Assumes W is a power of two and at least 2.
module zc_group_lzc #(
    parameter int unsigned W = zc_pkg::GROUP_W
) (
    input  logic [W-1:0]         bits_i,
    output logic [$clog2(W)-1:0] lead_o,
    output logic                 empty_o
);
    localparam int unsigned LW = $clog2(W);

    // Priority scan: the highest set bit wins because it is assigned last.
    always_comb begin
        lead_o = '0;
        for (int unsigned i = 0; i < W; i++) begin
            if (bits_i[i]) begin
                lead_o = LW'(W - 1 - i);
            end
        end
    end

    // All-zero flag for the group.
    assign empty_o = ~|bits_i;
endmodule

// File: rtl/zc_tree_lzc.sv
`timescale 1ns/1ps
// Module: zc_tree_lzc
// Two-level leading-zero count over WIDTH bits. The first level counts
// within groups of GROUP bits. The second level finds the first non-empty
// group and joins its index to that group's count. A vector of all zeros
// returns WIDTH.
// Assumes WIDTH and GROUP are powers of two and WIDTH/GROUP is at least 2.
module zc_tree_lzc #(
    parameter int unsigned WIDTH = zc_pkg::OPERAND_W,
    parameter int unsigned GROUP = zc_pkg::GROUP_W
) (
    input  logic [WIDTH-1:0]                      vec_i,
    output logic [zc_pkg::cnt_width(WIDTH)-1:0]   lead_o
);
    localparam int unsigned NGRP = WIDTH / GROUP;
    localparam int unsigned GW   = $clog2(GROUP);
    localparam int unsigned SW   = $clog2(NGRP);
    localparam int unsigned CW   = zc_pkg::cnt_width(WIDTH);

    logic [GW-1:0]   grp_lead [NGRP];
    logic [NGRP-1:0] grp_empty;
    logic [NGRP-1:0] grp_busy_rev;
    logic [SW-1:0]   first_grp;
    logic            none_set;

    // First level: group g covers the g-th slice counted from the top.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        zc_group_lzc #(.W(GROUP)) u_grp (
            .bits_i  (vec_i[WIDTH-1-g*GROUP -: GROUP]),
            .lead_o  (grp_lead[g]),
            .empty_o (grp_empty[g])
        );
        // Arrange occupancy so group 0 lands at the top bit.
        assign grp_busy_rev[NGRP-1-g] = ~grp_empty[g];
    end

    // Second level: leading-zero count over group occupancy.
    zc_group_lzc #(.W(NGRP)) u_sel (
        .bits_i  (grp_busy_rev),
        .lead_o  (first_grp),
        .empty_o (none_set)
    );

    // Join the group index and the in-group count, or saturate.
    always_comb begin
        if (none_set) begin
            lead_o = CW'(WIDTH);
        end else begin
            lead_o = CW'({first_grp, grp_lead[first_grp]});
        end
    end
endmodule

// File: rtl/zero_count_unit.sv
`timescale 1ns/1ps
// Module: zero_count_unit
// Combinational leading/trailing zero counter with a word mode. The result
// is the count, zero-extended to the operand width. The enclosing design
// must allow one clock period for the result to settle.
module zero_count_unit #(
    parameter int unsigned DATA_W  = zc_pkg::OPERAND_W,
    parameter int unsigned GROUP_W = zc_pkg::GROUP_W
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              from_lsb_i,
    input  logic              word_mode_i,
    output logic [DATA_W-1:0] count_o
);
    localparam int unsigned CW = zc_pkg::cnt_width(DATA_W);

    logic [DATA_W-1:0] scan_vec;
    logic [CW-1:0]     raw_count;

    zc_operand_prep #(.WIDTH(DATA_W)) u_prep (
        .operand_i   (operand_i),
        .from_lsb_i  (from_lsb_i),
        .word_mode_i (word_mode_i),
        .scan_o      (scan_vec)
    );

    zc_tree_lzc #(.WIDTH(DATA_W), .GROUP(GROUP_W)) u_tree (
        .vec_i  (scan_vec),
        .lead_o (raw_count)
    );

    // Zero-extend the count onto the full-width result.
    assign count_o = DATA_W'(raw_count);
endmodule

// File: rtl/zc_checker.sv
`timescale 1ns/1ps
// Module: zc_checker
// Property checks on the counter's ports. The unit has no clock, so these
// are immediate checks, evaluated only while every input is known.
module zc_checker #(
    parameter int unsigned DATA_W = zc_pkg::OPERAND_W
) (
    input logic [DATA_W-1:0] operand_i,
    input logic              from_lsb_i,
    input logic              word_mode_i,
    input logic [DATA_W-1:0] count_o
);
    localparam int unsigned HALF = DATA_W / 2;
    localparam int unsigned CW   = zc_pkg::cnt_width(DATA_W);

    // Port-level checks once the inputs carry known values.
    always_comb begin
        if (!$isunknown({operand_i, from_lsb_i, word_mode_i})) begin
            AST_UPPER_CLEAR: assert (count_o[DATA_W-1:CW] == '0) else $error("upper bits set"); // R1
            AST_FULL_ZERO_SAT: assert (word_mode_i || operand_i != '0 || count_o == DATA_W'(DATA_W)) else $error("full zero"); // R4
            AST_WORD_ZERO_SAT: assert (!word_mode_i || operand_i[HALF-1:0] != '0 || count_o == DATA_W'(HALF)) else $error("word zero"); // R8
            AST_WORD_CAPPED: assert (!word_mode_i || count_o <= DATA_W'(HALF)) else $error("word cap"); // R7
            AST_TOP_BIT_LEAD: assert (word_mode_i || from_lsb_i || !operand_i[DATA_W-1] || count_o == '0) else $error("msb set"); // R2
            AST_LOW_BIT_TRAIL: assert (!from_lsb_i || !operand_i[0] || count_o == '0) else $error("lsb set"); // R3
            AST_WORD_TOP_LEAD: assert (!word_mode_i || from_lsb_i || !operand_i[HALF-1] || count_o == '0) else $error("bit31 set"); // R6
        end
    end
endmodule

bind zero_count_unit zc_checker #(.DATA_W(DATA_W)) u_zc_checker (
    .operand_i   (operand_i),
    .from_lsb_i  (from_lsb_i),
    .word_mode_i (word_mode_i),
    .count_o     (count_o)
);

// File: tb/test_zero_count_unit.sv
`timescale 1ns/1ps
// Bench: sweeps a single set bit through every position in all four modes,
// with random fill on its far side. It then checks random operands and
// upper-word inversion against a loop-based reference count.
module test_zero_count_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand = '0;
    logic        from_lsb = 1'b0;
    logic        word_mode = 1'b0;
    logic [63:0] count;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    zero_count_unit i_zero_count_unit (
        .operand_i   (operand),
        .from_lsb_i  (from_lsb),
        .word_mode_i (word_mode),
        .count_o     (count)
    );

    // Reference: count zeros one bit at a time from the selected end.
    function automatic logic [63:0] ref_count(input logic [63:0] op, input bit lsb, input bit word);
        int w = word ? 32 : 64;
        for (int i = 0; i < w; i++) begin
            if (lsb ? op[i] : op[w-1-i]) return 64'(i);
        end
        return 64'(w);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive after a rising edge, sample at the next falling edge.
    task automatic apply(input logic [63:0] op, input bit lsb, input bit word);
        @(posedge clk);
        operand   = op;
        from_lsb  = lsb;
        word_mode = word;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] rnd;
        logic [63:0] op;
        logic [63:0] base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset state", count, 64'd64);
        rst_n = 1'b1;

        // All-zero operands in every mode.
        apply('0, 1'b0, 1'b0); check("R4 lead zero", count, 64'd64);
        apply('0, 1'b1, 1'b0); check("R4 trail zero", count, 64'd64);
        apply('0, 1'b0, 1'b1); check("R8 lead word zero", count, 64'd32);
        apply('0, 1'b1, 1'b1); check("R8 trail word zero", count, 64'd32);
        apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1); check("R8 lead upper ones", count, 64'd32);
        apply(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1); check("R8 trail upper ones", count, 64'd32);

        // Walking bit with random fill on the side that must not matter.
        for (int rep = 0; rep < 4; rep++) begin
            for (int p = 0; p < 64; p++) begin
                rnd = {$urandom, $urandom};
                op = (rnd & ~(~64'h0 << (p + 1))) | (64'h1 << p);
                apply(op, 1'b0, 1'b0); check("R2 lead walk", count, 64'(63 - p));
                apply(op, 1'b0, 1'b1); check("R6 lead word walk", count, ref_count(op, 1'b0, 1'b1));
                op = (rnd & ~((64'h1 << p) - 64'h1)) | (64'h1 << p);
                apply(op, 1'b1, 1'b0); check("R3 trail walk", count, 64'(p));
                op = (64'h1 << p) | (p >= 32 ? (rnd & ~((64'h1 << p) - 64'h1)) : 64'h0);
                apply(op, 1'b1, 1'b1); check("R7 trail word walk", count, (p < 32) ? 64'(p) : 64'd32);
            end
        end

        // Random operands, all modes, plus upper-word inversion in word mode.
        for (int k = 0; k < 200; k++) begin
            rnd = {$urandom, $urandom} >> ($urandom % 64);
            for (int m = 0; m < 4; m++) begin
                apply(rnd, m[0], m[1]);
                check("R1 random", count, ref_count(rnd, m[0], m[1]));
                if (m[1]) begin
                    base = count;
                    apply(rnd ^ 64'hFFFF_FFFF_0000_0000, m[0], 1'b1);
                    check("R5 upper ignored", count, base);
                end
            end
        end

        // Same-period response: change inputs, sample half a period later.
        apply(64'h0000_0000_0001_0000, 1'b1, 1'b0); check("R9 settle", count, 64'd16);
        apply(64'h0000_0000_0001_0000, 1'b0, 1'b0); check("R9 direction change", count, 64'd47);
        apply(64'h0000_0000_0001_0000, 1'b0, 1'b1); check("R9 mode change", count, 64'd15);

        finish_run();
    end
endmodule